// File: doc/BRIEF.md
# Serial Flash Read Responder

This block plays the target role on a four-wire serial flash link and answers the two read commands of a flash device. While chip select is low it collects an 8-bit command code and a 24-bit start address from the serial input, sampled on rising serial-clock edges. It then streams bytes on the serial output without limit. Each byte is fetched from a byte-wide synchronous memory read port that the block drives. The address advances by one per byte and wraps from the top of the indexed space back to zero.

The two recognised commands differ only in latency. The plain read starts output on the falling clock edge right after the last address bit. The fast read first swallows eight don't-care clocks. Any other command code puts the block into a silent state until chip select rises. Raising chip select ends a transfer at any bit and returns the block to command collection.

The serial pins are oversampled in the block's own clock domain through a short synchronizer. The serial clock must therefore run well below the system clock. It may idle low (mode 0) or high (mode 3).

Top module: `spi_flash_rd_resp`

## Requirements
- R1: After reset, and whenever chip select has been high for more than SYNC_STAGES+1 system clocks, spi_so_oe is 0 and mem_rd_en stays 0.
- R2: Command code 8'h03, shifted MSB first, followed by 24 address bits (bit 23 first) starts a plain read. The first data bit is driven from the first falling serial-clock edge after the last address bit, and the first byte is the memory byte at the received address.
- R3: Command code 8'h0B starts a fast read. The 8 clocks after the address are ignored whatever their data, and the first data bit is driven on the falling edge after the eighth of them.
- R4: Every data byte is sent MSB first. spi_so changes only just after a detected falling serial-clock edge, so it is stable at the next rising edge.
- R5: Bytes follow one another with no gap. Each byte comes from the address one above the previous byte's address, for as long as chip select stays low.
- R6: After the byte at the highest index (2^ADDR_BITS-1; 0x7FFFF by default) the next byte comes from index 0.
- R7: Only the low ADDR_BITS bits of the received address select the memory byte. Higher address bits have no effect on the data.
- R8: spi_so_oe is 0 during the command, address and dummy phases.
- R9: After an unrecognised command code, spi_so_oe stays 0 and no memory read is issued until chip select rises.
- R10: Chip select going high at any bit aborts the transfer. The next low period starts again with a command code.
- R11: Both serial-clock idle levels (low and high) give identical results.
- R12: Memory reads are single-cycle pulses. A transfer that delivers N complete bytes issues exactly N+1 reads: one when the header ends, and one at the last bit of each byte to prefetch the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for spi_so; 0 means high impedance |
| mem_rd_en | output | 1 | Memory read strobe, one cycle |
| mem_addr | output | ADDR_BITS | Memory byte index |
| mem_rdata | input | 8 | Memory data, valid the cycle after mem_rd_en |

## Verification
The bench builds the block with ADDR_BITS = 4, so the memory holds 16 bytes. This lets the sweep cover every start index under both commands and both clock idle levels. Three-byte reads from indices 14 and 15 cross the wrap point, and one long read passes it more than once. With the small space, address bits far above the index (bits 23 down to 4) can be set freely to show they are ignored. The default two synchronizer stages are kept so that serial timing matches the default build.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam logic [7:0] OPC_PLAIN_READ = 8'h03;
    localparam logic [7:0] OPC_FAST_READ  = 8'h0B;
    localparam int         ADDR_LEN       = 24;
    localparam int         DUMMY_LEN      = 8;
    localparam int         BYTE_LEN       = 8;
    localparam int         CNT_W          = $clog2(ADDR_LEN);

    typedef enum logic [2:0] {
        PH_OPCODE = 3'd0,
        PH_ADDR   = 3'd1,
        PH_DUMMY  = 3'd2,
        PH_DATA   = 3'd3,
        PH_SKIP   = 3'd4
    } phase_e;

    typedef struct packed {
        logic known;
        logic has_dummy;
    } cmd_info_t;

    function automatic cmd_info_t decode_opcode(input logic [7:0] code);
        cmd_info_t r;
        r.known     = (code == OPC_PLAIN_READ) || (code == OPC_FAST_READ);
        r.has_dummy = (code == OPC_FAST_READ);
        return r;
    endfunction

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_raw,
    input  logic cs_n_raw,
    input  logic si_raw,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_bit
);
    // bit order inside a stage: {sck, cs_n, si}
    localparam logic [2:0] STAGE_RST = 3'b010;

    logic [SYNC_STAGES-1:0][2:0] stage_q;
    logic                        sck_prev_q;
    logic [2:0]                  synced;

    assign synced = stage_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) begin
                stage_q[i] <= STAGE_RST;
            end
            sck_prev_q <= 1'b0;
        end else begin
            stage_q[0] <= {sck_raw, cs_n_raw, si_raw};
            for (int i = 1; i < SYNC_STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
            sck_prev_q <= synced[2];
        end
    end

    assign cs_act   = ~synced[1];
    assign sck_rise = synced[2] & ~sck_prev_q;
    assign sck_fall = ~synced[2] & sck_prev_q;
    assign si_bit   = synced[0];

endmodule

// File: rtl/spi_rd_cmd_fsm.sv
module spi_rd_cmd_fsm
    import spi_rd_pkg::*;
#(
    parameter int ADDR_BITS = 19
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_act,
    input  logic                 sck_rise,
    input  logic                 si_bit,
    output phase_e               phase,
    output logic                 rd_en,
    output logic [ADDR_BITS-1:0] rd_addr
);
    localparam logic [CNT_W-1:0] LAST_OPC   = CNT_W'(BYTE_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_ADDR  = CNT_W'(ADDR_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_LEN - 1);
    localparam logic [ADDR_BITS-1:0] ONE_IDX = ADDR_BITS'(1);

    logic [CNT_W-1:0]     bit_cnt;
    logic [ADDR_LEN-1:0]  shreg;
    logic [ADDR_LEN-1:0]  shifted;
    logic                 fast_q;
    logic [ADDR_BITS-1:0] ptr_q;
    cmd_info_t            info;
    logic                 fetch;
    logic [ADDR_BITS-1:0] fetch_idx;

    assign shifted = {shreg[ADDR_LEN-2:0], si_bit};
    assign info    = decode_opcode(shifted[7:0]);

    always_comb begin
        fetch = 1'b0;
        if (cs_act && sck_rise) begin
            case (phase)
                PH_ADDR:  fetch = (bit_cnt == LAST_ADDR) && !fast_q;
                PH_DUMMY: fetch = (bit_cnt == LAST_DUMMY);
                PH_DATA:  fetch = (bit_cnt[2:0] == 3'd7);
                default:  fetch = 1'b0;
            endcase
        end
        fetch_idx = (phase == PH_ADDR) ? shifted[ADDR_BITS-1:0] : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            phase   <= PH_OPCODE;
            bit_cnt <= '0;
            shreg   <= '0;
            fast_q  <= 1'b0;
            ptr_q   <= '0;
        end else if (sck_rise) begin
            case (phase)
                PH_OPCODE: begin
                    shreg <= shifted;
                    if (bit_cnt == LAST_OPC) begin
                        bit_cnt <= '0;
                        fast_q  <= info.has_dummy;
                        phase   <= info.known ? PH_ADDR : PH_SKIP;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    shreg <= shifted;
                    if (bit_cnt == LAST_ADDR) begin
                        bit_cnt <= '0;
                        phase   <= fast_q ? PH_DUMMY : PH_DATA;
                        ptr_q   <= fast_q ? shifted[ADDR_BITS-1:0]
                                          : shifted[ADDR_BITS-1:0] + ONE_IDX;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_DUMMY: begin
                    if (bit_cnt == LAST_DUMMY) begin
                        bit_cnt <= '0;
                        phase   <= PH_DATA;
                        ptr_q   <= ptr_q + ONE_IDX;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (fetch) begin
                        ptr_q <= ptr_q + ONE_IDX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            rd_en   <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_en <= fetch;
            if (fetch) begin
                rd_addr <= fetch_idx;
            end
        end
    end

endmodule

// File: rtl/spi_rd_tx_shift.sv
module spi_rd_tx_shift
    import spi_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_act,
    input  logic       sck_fall,
    input  logic       in_data,
    input  logic       fill_valid,
    input  logic [7:0] fill_byte,
    output logic       so_bit,
    output logic       drive
);
    logic [7:0] hold_q;
    logic [7:0] sh_q;
    logic [2:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            hold_q <= '0;
            sh_q   <= '0;
            cnt_q  <= '0;
            drive  <= 1'b0;
        end else begin
            if (fill_valid) begin
                hold_q <= fill_byte;
            end
            if (sck_fall && in_data) begin
                drive <= 1'b1;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == 3'd0) begin
                    sh_q <= hold_q;
                end else begin
                    sh_q <= {sh_q[6:0], 1'b0};
                end
            end
        end
    end

    assign so_bit = sh_q[7];

endmodule

// File: rtl/spi_flash_rd_resp.sv
module spi_flash_rd_resp
    import spi_rd_pkg::*;
#(
    parameter int ADDR_BITS   = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 spi_sck,
    input  logic                 spi_cs_n,
    input  logic                 spi_si,
    output logic                 spi_so,
    output logic                 spi_so_oe,
    output logic                 mem_rd_en,
    output logic [ADDR_BITS-1:0] mem_addr,
    input  logic [7:0]           mem_rdata
);
    logic   cs_act;
    logic   sck_rise;
    logic   sck_fall;
    logic   si_bit;
    phase_e phase;
    logic   rvalid_q;
    logic   so_bit;
    logic   drive;

    spi_rd_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .sck_raw  (spi_sck),
        .cs_n_raw (spi_cs_n),
        .si_raw   (spi_si),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_bit   (si_bit)
    );

    spi_rd_cmd_fsm #(.ADDR_BITS(ADDR_BITS)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .si_bit   (si_bit),
        .phase    (phase),
        .rd_en    (mem_rd_en),
        .rd_addr  (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= mem_rd_en;
        end
    end

    spi_rd_tx_shift tx_i (
        .clk        (clk),
        .rst        (rst),
        .cs_act     (cs_act),
        .sck_fall   (sck_fall),
        .in_data    (phase == PH_DATA),
        .fill_valid (rvalid_q),
        .fill_byte  (mem_rdata),
        .so_bit     (so_bit),
        .drive      (drive)
    );

    assign spi_so_oe = drive & cs_act;
    assign spi_so    = so_bit & spi_so_oe;

endmodule

// File: rtl/spi_rd_resp_chk.sv
module spi_rd_resp_chk
    import spi_rd_pkg::*;
#(
    parameter int ADDR_BITS   = 19,
    parameter int SYNC_STAGES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 spi_cs_n,
    input logic                 cs_act,
    input logic                 sck_fall,
    input phase_e               phase,
    input logic                 spi_so,
    input logic                 spi_so_oe,
    input logic                 mem_rd_en,
    input logic [ADDR_BITS-1:0] mem_addr
);
    logic [3:0]           idle_cnt;
    logic                 have_last;
    logic [ADDR_BITS-1:0] last_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt  <= '0;
            have_last <= 1'b0;
            last_addr <= '0;
        end else begin
            if (!spi_cs_n) idle_cnt <= '0;
            else if (idle_cnt != 4'hF) idle_cnt <= idle_cnt + 1'b1;
            if (!cs_act) begin
                have_last <= 1'b0;
            end else if (mem_rd_en) begin
                have_last <= 1'b1;
                last_addr <= mem_addr;
            end
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt > 4'(SYNC_STAGES + 1)) |-> (!spi_so_oe && !mem_rd_en));

    // R4
    so_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_so_oe && $past(spi_so_oe) && (spi_so != $past(spi_so))) |-> $past(sck_fall));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && have_last && cs_act) |-> (mem_addr == last_addr + ADDR_BITS'(1)));

    // R8
    header_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OPCODE || phase == PH_ADDR || phase == PH_DUMMY) |-> !spi_so_oe);

    // R9
    skip_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> (!spi_so_oe && !mem_rd_en));

    // R12
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

endmodule

bind spi_flash_rd_resp spi_rd_resp_chk #(
    .ADDR_BITS   (ADDR_BITS),
    .SYNC_STAGES (SYNC_STAGES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .spi_cs_n  (spi_cs_n),
    .cs_act    (cs_act),
    .sck_fall  (sck_fall),
    .phase     (phase),
    .spi_so    (spi_so),
    .spi_so_oe (spi_so_oe),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr)
);

// File: tb/spi_flash_rd_resp_tb.sv
module spi_flash_rd_resp_tb_top;
    localparam int AB = 4;
    localparam int H  = 6;   // system clocks per serial half period

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          spi_sck = 1'b0;
    logic          spi_cs_n = 1'b1;
    logic          spi_si = 1'b0;
    logic          spi_so;
    logic          spi_so_oe;
    logic          mem_rd_en;
    logic [AB-1:0] mem_addr;
    logic [7:0]    mem_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    int rd_count = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    spi_flash_rd_resp #(.ADDR_BITS(AB), .SYNC_STAGES(2)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_si    (spi_si),
        .spi_so    (spi_so),
        .spi_so_oe (spi_so_oe),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] pattern(input int idx);
        return 8'((idx % (1 << AB)) * 29 + 90);
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= pattern(int'(mem_addr));
        if (mem_rd_en) rd_count <= rd_count + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one host-driven bit; records whether the output was ever enabled
    task automatic put_bit(input logic b, inout bit saw_oe);
        spi_sck = 1'b0;
        spi_si  = b;
        wait_clk(H);
        if (spi_so_oe) saw_oe = 1'b1;
        spi_sck = 1'b1;
        wait_clk(H);
    endtask

    task automatic put_byte(input logic [7:0] v, inout bit saw_oe);
        for (int i = 7; i >= 0; i--) put_bit(v[i], saw_oe);
    endtask

    task automatic get_bit(output logic b, inout bit oe_ok);
        spi_sck = 1'b0;
        wait_clk(H);
        b = spi_so;
        if (!spi_so_oe) oe_ok = 1'b0;
        spi_sck = 1'b1;
        wait_clk(H);
    endtask

    task automatic begin_txn(input bit mode3);
        spi_sck = mode3;
        wait_clk(2);
        spi_cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic end_txn(input bit mode3);
        if (!mode3) begin
            spi_sck = 1'b0;
            wait_clk(H);
        end
        spi_cs_n = 1'b1;
        wait_clk(6);
        check(!spi_so_oe, "R1/R10 idle hi-z", spi_so_oe, 0);
    endtask

    // full read: header, nbytes complete bytes, tail extra bits, then CS high
    task automatic run_read(input bit mode3, input logic [7:0] op, input logic [23:0] addr,
                            input logic [7:0] dummy, input int nbytes, input int tail,
                            input string req);
        bit   saw_oe = 1'b0;
        int   rd0;
        int   base;
        logic b;
        rd0  = rd_count;
        base = int'(addr[AB-1:0]);
        begin_txn(mode3);
        put_byte(op, saw_oe);
        for (int i = 23; i >= 0; i--) put_bit(addr[i], saw_oe);
        if (op == 8'h0B) put_byte(dummy, saw_oe);
        check(!saw_oe, {req, " R8 header hi-z"}, saw_oe, 0);
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] got;
            bit oe_ok = 1'b1;
            for (int i = 7; i >= 0; i--) begin
                get_bit(b, oe_ok);
                got[i] = b;
            end
            check(oe_ok && got == pattern(base + k),
                  $sformatf("%s R4 R5 R6 R11 byte %0d mode3=%0d", req, k, mode3),
                  got, pattern(base + k));
        end
        for (int t = 0; t < tail; t++) begin
            bit oe_ok = 1'b1;
            get_bit(b, oe_ok);
        end
        end_txn(mode3);
        if (tail == 0)
            check(rd_count - rd0 == nbytes + 1, {req, " R12 read count"}, rd_count - rd0, nbytes + 1);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(10);
        // R1: reset state
        check(!spi_so_oe, "R1 oe after reset", spi_so_oe, 0);
        check(rd_count == 0, "R1 no reads after reset", rd_count, 0);

        // R2 R3 R6 R11: sweep every start index, both commands, both idle levels
        for (int m = 0; m < 2; m++) begin
            for (int op = 0; op < 2; op++) begin
                for (int a = 0; a < (1 << AB); a++) begin
                    run_read(m[0], op[0] ? 8'h0B : 8'h03, 24'(a),
                             op[0] ? 8'(a * 17) : 8'h00, 3, 0, op[0] ? "R3" : "R2");
                end
            end
        end

        // R6: long read crossing the top twice
        run_read(1'b0, 8'h03, 24'd13, 8'h00, 20, 0, "R6 long");
        // R7: high address bits ignored
        run_read(1'b0, 8'h03, 24'hFFFFF3, 8'h00, 2, 0, "R7 high bits");
        run_read(1'b1, 8'h0B, 24'h80007, 8'hFF, 2, 0, "R7 fast high bits");
        // R3: dummy byte content irrelevant
        run_read(1'b0, 8'h0B, 24'd5, 8'hA5, 2, 0, "R3 dummy A5");

        // R9: unknown command, then recovery (R10)
        begin
            bit saw_oe = 1'b0;
            int rd0;
            rd0 = rd_count;
            begin_txn(1'b0);
            put_byte(8'h9F, saw_oe);
            for (int i = 0; i < 40; i++) put_bit(i[0], saw_oe);
            check(!saw_oe, "R9 unknown opcode silent", saw_oe, 0);
            check(rd_count == rd0, "R9 unknown opcode no reads", rd_count - rd0, 0);
            end_txn(1'b0);
        end
        run_read(1'b0, 8'h03, 24'd6, 8'h00, 1, 0, "R10 after unknown");

        // R10: abort mid-byte and mid-address, then a clean read
        run_read(1'b1, 8'h03, 24'd3, 8'h00, 1, 3, "R10 abort data");
        begin
            bit saw_oe = 1'b0;
            begin_txn(1'b0);
            put_byte(8'h0B, saw_oe);
            for (int i = 0; i < 11; i++) put_bit(1'b1, saw_oe);
            end_txn(1'b0);
        end
        run_read(1'b0, 8'h03, 24'd9, 8'h00, 2, 0, "R10 after abort");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule